// File: doc/BRIEF.md
# Table-Driven Two-Bit Gray Counter

This block is a synchronous two-bit counter that walks the reflected Gray sequence, so exactly one output bit toggles on every counting step. Two controls steer it: a count enable that freezes or releases the counter, and a direction select that chooses between forward and reverse stepping. The registered state is the block's output; no output decoding stage follows the flip-flops.

The next state is not produced by increment logic. It is read from a constant sixteen-word lookup table. The two present-state bits form the high half of the table address, the direction select is address bit 1 and the enable is address bit 0. The table is built at elaboration time: it starts with every word at zero and then has only the entries that need a nonzero next state written into it. A parameter can swap the table for a multiplexer path instead. In that path the present state drives the select lines of one four-input multiplexer per state bit, and each data input carries a reduced function of the two controls. Both paths feed the same state register.

The states are named by the value they hold: S00, S01, S11 and S10. Forward steps are S00→S01, S01→S11, S11→S10 and S10→S00. Reverse steps are the same arcs taken the other way. Each state also has a self-loop that is taken whenever the enable is low.

Top module: `gray_step_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 00 at that edge, whatever the controls are.
- R2: With `cnt_en` low, the state after an edge equals the state before it, for both values of `dir_up`.
- R3: With `cnt_en` high and `dir_up` high, the state advances 00→01→11→10→00, one step per edge.
- R4: With `cnt_en` high and `dir_up` low, the state steps backward 00→10→11→01→00, one step per edge.
- R5: No single edge changes more than one output bit.
- R6: For all sixteen combinations of present state (address bits 3:2), `dir_up` (bit 1) and `cnt_en` (bit 0), the next state matches the Gray model. Words that are never programmed read as 00.
- R7: The multiplexer variant (`USE_MUX`=1) produces the same state sequence as the table variant for identical stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable; low holds the state |
| dir_up | input | 1 | 1 steps forward, 0 steps backward |
| state_q | output | 2 | Registered Gray state |

## Verification
The hardest cases to reach are the table words whose address pairs a given present state with a given control code. A state can only be reached by counting into it, so the stimulus first steps forward with the enable high until the reference model reports the target state. It then applies one of the four control codes, and repeats this for all sixteen pairs. The table variant and the multiplexer variant run in parallel from the same driver, and every expected value is compared against both of them.

// File: rtl/gray_cnt_pkg.sv
package gray_cnt_pkg;

    localparam int STATE_W = 2;
    localparam int CTRL_W  = 2;
    localparam int ADDR_W  = STATE_W + CTRL_W;
    localparam int DEPTH   = 1 << ADDR_W;

    typedef enum logic [STATE_W-1:0] {
        S00 = 2'b00,
        S01 = 2'b01,
        S11 = 2'b11,
        S10 = 2'b10
    } gray_state_e;

    typedef logic [DEPTH-1:0][STATE_W-1:0] nsd_table_t;

    // forward neighbour on the Gray ring
    function automatic logic [STATE_W-1:0] gray_fwd(input logic [STATE_W-1:0] s);
        logic [STATE_W-1:0] n;
        unique case (s)
            2'b00:   n = 2'b01;
            2'b01:   n = 2'b11;
            2'b11:   n = 2'b10;
            default: n = 2'b00;
        endcase
        return n;
    endfunction

    // backward neighbour on the Gray ring
    function automatic logic [STATE_W-1:0] gray_rev(input logic [STATE_W-1:0] s);
        logic [STATE_W-1:0] n;
        unique case (s)
            2'b00:   n = 2'b10;
            2'b10:   n = 2'b11;
            2'b11:   n = 2'b01;
            default: n = 2'b00;
        endcase
        return n;
    endfunction

    // table starts all-zero; only nonzero next states are written
    function automatic nsd_table_t build_nsd_table();
        nsd_table_t t;
        logic [STATE_W-1:0] ps;
        logic [STATE_W-1:0] ns;
        t = '0;
        for (int a = 0; a < DEPTH; a++) begin
            ps = STATE_W'(a >> CTRL_W);
            if (a[0] == 1'b0)      ns = ps;
            else if (a[1] == 1'b1) ns = gray_fwd(ps);
            else                   ns = gray_rev(ps);
            if (ns != '0) t[a] = ns;
        end
        return t;
    endfunction

endpackage

// File: rtl/gray_nsd_rom.sv
module gray_nsd_rom
    import gray_cnt_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    output logic [STATE_W-1:0] data
);
    localparam nsd_table_t NSD_TABLE = build_nsd_table();

    always_comb begin
        data = NSD_TABLE[addr];
    end

endmodule

// File: rtl/gray_nsd_mux.sv
module gray_nsd_mux
    import gray_cnt_pkg::*;
(
    input  logic [STATE_W-1:0] cur,
    input  logic               dir_up,
    input  logic               cnt_en,
    output logic [STATE_W-1:0] nxt
);
    // per-bit mux data inputs, indexed by present state
    logic [STATE_W-1:0] din [4];

    always_comb begin
        // bit 1 inputs
        din[0][1] =  cnt_en & ~dir_up;
        din[1][1] =  cnt_en &  dir_up;
        din[3][1] = ~cnt_en |  dir_up;
        din[2][1] = ~cnt_en | ~dir_up;
        // bit 0 inputs
        din[0][0] =  cnt_en &  dir_up;
        din[1][0] = ~cnt_en |  dir_up;
        din[3][0] = ~cnt_en | ~dir_up;
        din[2][0] =  cnt_en & ~dir_up;
    end

    for (genvar b = 0; b < STATE_W; b++) begin : g_bit_mux
        always_comb begin
            unique case (cur)
                2'b00:   nxt[b] = din[0][b];
                2'b01:   nxt[b] = din[1][b];
                2'b11:   nxt[b] = din[3][b];
                default: nxt[b] = din[2][b];
            endcase
        end
    end

endmodule

// File: rtl/gray_state_reg.sv
module gray_state_reg
    import gray_cnt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] d,
    output gray_state_e        q
);
    gray_state_e d_st;

    always_comb begin
        d_st = gray_state_e'(d);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= S00;
        else     q <= d_st;
    end

    assert_reset_zero_R1: assert property (@(posedge clk) rst |=> (q == S00))
        else $error("R1: state not cleared by reset");

endmodule

// File: rtl/gray_step_counter.sv
module gray_step_counter
    import gray_cnt_pkg::*;
#(
    parameter bit USE_MUX = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cnt_en,
    input  logic               dir_up,
    output logic [STATE_W-1:0] state_q
);
    logic [STATE_W-1:0] next_s;
    gray_state_e        cur_st;

    if (USE_MUX) begin : g_mux_path
        gray_nsd_mux u_nsd (
            .cur    (state_q),
            .dir_up (dir_up),
            .cnt_en (cnt_en),
            .nxt    (next_s)
        );
    end else begin : g_rom_path
        gray_nsd_rom u_nsd (
            .addr ({state_q, dir_up, cnt_en}),
            .data (next_s)
        );
    end

    gray_state_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (next_s),
        .q   (cur_st)
    );

    always_comb begin
        state_q = cur_st;
    end

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> (state_q == $past(state_q)))
        else $error("R2: state moved while disabled");

    assert_step_fwd_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && dir_up) |=> (state_q == gray_fwd($past(state_q))))
        else $error("R3: bad forward step");

    assert_step_rev_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !dir_up) |=> (state_q == gray_rev($past(state_q))))
        else $error("R4: bad reverse step");

    assert_single_toggle_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(state_q ^ $past(state_q)) <= 1))
        else $error("R5: more than one bit toggled");

endmodule

// File: tb/gray_step_counter_test.sv
module gray_step_counter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       dir_up = 1'b0;
    logic [1:0] q_rom;
    logic [1:0] q_mux;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [1:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    logic [1:0] model = 2'b00;

    always #2 clk = ~clk;

    gray_step_counter #(.USE_MUX(1'b0)) uut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .dir_up(dir_up), .state_q(q_rom)
    );

    gray_step_counter #(.USE_MUX(1'b1)) uut_mux (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .dir_up(dir_up), .state_q(q_mux)
    );

    // reference: position on the ring 0,1,3,2
    function automatic logic [1:0] ring_at(input int idx);
        logic [1:0] seq [4];
        seq[0] = 2'b00; seq[1] = 2'b01; seq[2] = 2'b11; seq[3] = 2'b10;
        return seq[((idx % 4) + 4) % 4];
    endfunction

    function automatic int ring_pos(input logic [1:0] s);
        for (int i = 0; i < 4; i++) if (ring_at(i) == s) return i;
        return 0;
    endfunction

    task automatic drive(input logic r, input logic e, input logic d, input string tag);
        sb_item_t it;
        @(negedge clk);
        rst = r; cnt_en = e; dir_up = d;
        if (r)      model = 2'b00;
        else if (e) model = ring_at(ring_pos(model) + (d ? 1 : -1));
        it.exp = model;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor
    initial begin
        sb_item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                n_checks++;
                if (q_rom !== it.exp) begin
                    n_fails++;
                    $display("FAIL %s table path: actual %b expected %b", it.tag, q_rom, it.exp);
                end
                n_checks++;
                if (q_mux !== it.exp) begin
                    n_fails++;
                    $display("FAIL %s mux path (R7): actual %b expected %b", it.tag, q_mux, it.exp);
                end
            end
        end
    end

    // watchdog
    initial begin
        #20000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset with controls active
        drive(1'b1, 1'b1, 1'b1, "R1");
        drive(1'b1, 1'b1, 1'b0, "R1");
        // R3: full forward lap
        for (int i = 0; i < 5; i++) drive(1'b0, 1'b1, 1'b1, "R3");
        // R2: hold in both directions
        drive(1'b0, 1'b0, 1'b1, "R2");
        drive(1'b0, 1'b0, 1'b0, "R2");
        // R4: full reverse lap
        for (int i = 0; i < 5; i++) drive(1'b0, 1'b1, 1'b0, "R4");
        // R5: alternate directions
        for (int i = 0; i < 6; i++) drive(1'b0, 1'b1, i[0], "R5");
        // R1: reset mid-count
        drive(1'b1, 1'b0, 1'b0, "R1");
        // R6: every state against every control code
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 4; c++) begin
                drive(1'b1, 1'b0, 1'b0, "R6");
                while (model != ring_at(s)) drive(1'b0, 1'b1, 1'b1, "R6");
                drive(1'b0, c[0], c[1], "R6");
            end
        end
        drive(1'b0, 1'b0, 1'b0, "R2");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule